// File: doc/BRIEF.md
# Collision Vector Generator

This block takes the reservation table of a static pipeline and works out which initiation latencies are forbidden. The table is a bit matrix with one row per stage and one column per clock cycle of the evaluation. A mark at row s, column t means stage s is occupied in cycle t. A latency k is forbidden when any single row holds two marks exactly k columns apart, because two evaluations started k cycles apart would then need that stage in the same cycle.

A start pulse captures the table. The block then tests one latency per clock, from 1 up to the evaluation time minus one. For each latency it ANDs each row with a copy of itself shifted by that latency and ORs the results over all rows. At the end it raises a one-cycle done strobe. It reports three results: the collision vector, the largest forbidden latency, and the number of forbidden latencies. The count plus one is an upper bound on the minimum average latency of the pipeline, so a scheduler can form that bound directly.

Top module: `cvec_gen`

## Requirements
- R1: After reset, busy_o and done_o are 0, and cvec_o, max_lat_o and num_forb_o are all zero.
- R2: When done_o is high, bit i-1 of cvec_o (the bit for latency i) is 1 exactly when some stage row holds marks in two columns that are i apart. Table encoding: row s occupies table_i[s*NUM_COLS +: NUM_COLS], and bit t-1 of that slice is column t.
- R3: max_lat_o is the largest forbidden latency, which is the position (counting from 1) of the highest set bit of cvec_o. It is 0 when no latency is forbidden, and every bit of cvec_o above it is 0.
- R4: num_forb_o equals the number of 1 bits in cvec_o.
- R5: A start accepted at a clock edge puts busy_o high. done_o is high for exactly one cycle, following the edge that comes NUM_COLS-1 edges after the accepting edge, and busy_o is low again in that cycle.
- R6: The table is sampled only at the accepting edge. Changes on table_i during a scan do not affect the results.
- R7: start_i is ignored while busy_o is high. No extra scan runs and no extra done_o pulse follows.
- R8: The results hold their values while the block is idle, until the next start is accepted.
- R9: A table in which no stage row is used more than once gives cvec_o = 0, max_lat_o = 0 and num_forb_o = 0.
- R10: The full range works at the boundary. A row marked in every column forbids every latency from 1 to NUM_COLS-1. A row marked only in the first and last columns forbids only latency NUM_COLS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a scan; accepted only while idle |
| table_i | input | NUM_STAGES*NUM_COLS | Reservation table, one NUM_COLS-bit slice per stage |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle strobe when the results are ready |
| cvec_o | output | NUM_COLS-1 | Collision vector; bit i-1 is set when latency i is forbidden |
| max_lat_o | output | $clog2(NUM_COLS) | Largest forbidden latency, 0 when none |
| num_forb_o | output | $clog2(NUM_COLS) | Number of forbidden latencies |

## Verification
The checker tests, on every cycle, the properties that relate the results to each other and to the control flow. These are: the highest set bit of the vector against the reported maximum, the population count against the reported count, the empty-table case, the one-cycle done strobe that follows a scan, and the results holding steady while idle. Whether each vector bit is correct for the table that was loaded can only be shown by the bench scenarios, which compare against a reference computed from pairs of marks. The same applies to the exact done latency, and to tables or starts presented during a scan having no effect.

// File: rtl/cv_pkg.sv
package cv_pkg;
  typedef enum logic {
    CV_IDLE = 1'b0,
    CV_SCAN = 1'b1
  } cv_state_e;
endpackage

// File: rtl/cv_row_match.sv
// One stage row: any pair of marks exactly lat_i columns apart.
module cv_row_match #(
  parameter int NUM_COLS = 16,
  localparam int LAT_W = $clog2(NUM_COLS)
) (
  input  logic [NUM_COLS-1:0] row_i,
  input  logic [LAT_W-1:0]    lat_i,
  output logic                hit_o
);
  logic [NUM_COLS-1:0] shifted;

  assign shifted = row_i >> lat_i;
  assign hit_o   = |(row_i & shifted);
endmodule

// File: rtl/cv_scan_ctrl.sv
module cv_scan_ctrl import cv_pkg::*; #(
  parameter int NUM_COLS = 16,
  localparam int LAT_W = $clog2(NUM_COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic [LAT_W-1:0] lat_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [LAT_W-1:0] LastLat = LAT_W'(NUM_COLS - 1);
  localparam logic [LAT_W-1:0] FirstLat = LAT_W'(1);

  cv_state_e        state_q;
  logic [LAT_W-1:0] lat_q;
  logic             done_q;

  assign load_o = (state_q == CV_IDLE) && start_i;
  assign step_o = (state_q == CV_SCAN);
  assign busy_o = (state_q == CV_SCAN);
  assign lat_o  = lat_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CV_IDLE;
      lat_q   <= FirstLat;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        CV_IDLE: begin
          if (start_i) begin
            state_q <= CV_SCAN;
            lat_q   <= FirstLat;
          end
        end
        CV_SCAN: begin
          if (lat_q == LastLat) begin
            state_q <= CV_IDLE;
            done_q  <= 1'b1;
          end else begin
            lat_q <= lat_q + 1'b1;
          end
        end
        default: state_q <= CV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cv_result_acc.sv
module cv_result_acc #(
  parameter int NUM_COLS = 16,
  localparam int VEC_W = NUM_COLS - 1,
  localparam int LAT_W = $clog2(NUM_COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             hit_i,
  output logic [VEC_W-1:0] vec_o,
  output logic [LAT_W-1:0] max_o,
  output logic [LAT_W-1:0] cnt_o
);
  logic [VEC_W-1:0] vec_q;
  logic [LAT_W-1:0] max_q;
  logic [LAT_W-1:0] cnt_q;
  logic [VEC_W-1:0] lat_bit;

  // latency i lands on bit i-1
  assign lat_bit = VEC_W'(1) << (lat_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      max_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      vec_q <= '0;
      max_q <= '0;
      cnt_q <= '0;
    end else if (step_i && hit_i) begin
      vec_q <= vec_q | lat_bit;
      max_q <= lat_i;  // ascending scan: last hit is the largest
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign vec_o = vec_q;
  assign max_o = max_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/cvec_gen.sv
module cvec_gen import cv_pkg::*; #(
  parameter int NUM_STAGES = 8,
  parameter int NUM_COLS   = 16,
  localparam int VEC_W = NUM_COLS - 1,
  localparam int LAT_W = $clog2(NUM_COLS),
  localparam int TBL_W = NUM_STAGES * NUM_COLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TBL_W-1:0] table_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [VEC_W-1:0] cvec_o,
  output logic [LAT_W-1:0] max_lat_o,
  output logic [LAT_W-1:0] num_forb_o
);
  logic [TBL_W-1:0]      tbl_q;
  logic                  load;
  logic                  step;
  logic [LAT_W-1:0]      lat;
  logic [NUM_STAGES-1:0] row_hit;
  logic                  any_hit;

  cv_scan_ctrl #(.NUM_COLS(NUM_COLS)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .lat_o  (lat),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tbl_q <= '0;
    else if (load) tbl_q <= table_i;
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_row
    cv_row_match #(.NUM_COLS(NUM_COLS)) u_match (
      .row_i(tbl_q[g*NUM_COLS +: NUM_COLS]),
      .lat_i(lat),
      .hit_o(row_hit[g])
    );
  end

  assign any_hit = |row_hit;

  cv_result_acc #(.NUM_COLS(NUM_COLS)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load),
    .step_i(step),
    .lat_i (lat),
    .hit_i (any_hit),
    .vec_o (cvec_o),
    .max_o (max_lat_o),
    .cnt_o (num_forb_o)
  );
endmodule

// File: rtl/cvec_gen_chk.sv
module cvec_gen_chk #(
  parameter int NUM_COLS = 16,
  localparam int VEC_W = NUM_COLS - 1,
  localparam int LAT_W = $clog2(NUM_COLS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [VEC_W-1:0] cvec_o,
  input logic [LAT_W-1:0] max_lat_o,
  input logic [LAT_W-1:0] num_forb_o
);
  a_r3_top_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (max_lat_o != '0) |-> cvec_o[max_lat_o - 1'b1]);

  a_r3_zero_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((cvec_o >> max_lat_o) == '0));

  a_r4_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (32'(num_forb_o) == 32'($countones(cvec_o))));

  a_r9_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (max_lat_o == '0) |-> (cvec_o == '0) && (num_forb_o == '0));

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_after_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o);

  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(cvec_o) && $stable(max_lat_o) && $stable(num_forb_o));
endmodule

bind cvec_gen cvec_gen_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .cvec_o    (cvec_o),
  .max_lat_o (max_lat_o),
  .num_forb_o(num_forb_o)
);

// File: tb/cvec_gen_test.sv
module cvec_gen_test;
  localparam int NS = 8;
  localparam int NC = 16;
  localparam int VW = NC - 1;
  localparam int LW = $clog2(NC);
  localparam int TW = NS * NC;

  typedef struct {
    logic [VW-1:0] vec;
    logic [LW-1:0] mx;
    logic [LW-1:0] cnt;
    int            acc_cyc;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [TW-1:0] table_i = '0;
  logic          busy_o, done_o;
  logic [VW-1:0] cvec_o;
  logic [LW-1:0] max_lat_o, num_forb_o;

  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  int   dones = 0;
  bit   finished = 1'b0;
  exp_t sb[$];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cvec_gen #(.NUM_STAGES(NS), .NUM_COLS(NC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .table_i(table_i),
    .busy_o(busy_o), .done_o(done_o), .cvec_o(cvec_o),
    .max_lat_o(max_lat_o), .num_forb_o(num_forb_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void mark(ref logic [TW-1:0] t, input int s, input int c);
    t[s*NC + c - 1] = 1'b1;
  endfunction

  // reference: distance between every pair of marks in a row (R2, R3, R4)
  function automatic exp_t model(input logic [TW-1:0] t, input string tag);
    exp_t e;
    e.vec = '0; e.mx = '0; e.cnt = '0; e.acc_cyc = 0; e.tag = tag;
    for (int s = 0; s < NS; s++)
      for (int a = 1; a <= NC; a++)
        for (int b = a + 1; b <= NC; b++)
          if (t[s*NC + a - 1] && t[s*NC + b - 1]) e.vec[b - a - 1] = 1'b1;
    for (int i = 1; i <= VW; i++)
      if (e.vec[i-1]) begin
        e.mx  = LW'(i);
        e.cnt = e.cnt + 1'b1;
      end
    return e;
  endfunction

  function automatic logic [31:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // driver: start a scan, push the expectation, wait for the monitor
  task automatic run(input logic [TW-1:0] t, input string tag);
    exp_t e;
    e = model(t, tag);
    @(negedge clk);
    table_i = t;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    e.acc_cyc = cyc;
    sb.push_back(e);
    chk(busy_o === 1'b1, "R5", {tag, " busy after start"}, 32'(busy_o), 32'd1);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare each result as done appears
  always @(negedge clk) begin
    if (rst_n && done_o === 1'b1) begin
      exp_t e;
      dones++;
      if (sb.size() == 0) begin
        chk(1'b0, "R7", "unexpected done", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        chk(cvec_o === e.vec, "R2", {e.tag, " vector"}, 32'(cvec_o), 32'(e.vec));
        chk(max_lat_o === e.mx, "R3", {e.tag, " max latency"}, 32'(max_lat_o), 32'(e.mx));
        chk(num_forb_o === e.cnt, "R4", {e.tag, " count"}, 32'(num_forb_o), 32'(e.cnt));
        chk(cyc == e.acc_cyc + NC - 1, "R5", {e.tag, " done timing"}, 32'(cyc), 32'(e.acc_cyc + NC - 1));
        chk(busy_o === 1'b0, "R5", {e.tag, " busy at done"}, 32'(busy_o), 32'd0);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [TW-1:0] t, t2;
    exp_t e;
    int d0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o === 1'b0, "R1", "busy", 32'(busy_o), 0);
    chk(done_o === 1'b0, "R1", "done", 32'(done_o), 0);
    chk(cvec_o === '0, "R1", "vector", 32'(cvec_o), 0);
    chk(max_lat_o === '0, "R1", "max", 32'(max_lat_o), 0);
    chk(num_forb_o === '0, "R1", "count", 32'(num_forb_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: latencies 2,4,5,7 -> 1011010
    t = '0;
    mark(t, 0, 1); mark(t, 0, 3);
    mark(t, 1, 1); mark(t, 1, 5);
    mark(t, 2, 1); mark(t, 2, 6);
    mark(t, 3, 1); mark(t, 3, 8);
    e = model(t, "");
    chk(e.vec === 15'b1011010, "R2", "model sanity 1011010", 32'(e.vec), 32'h5A);
    run(t, "R2 four-rows");

    // R2 three-stage, five-column: latencies 1,2,4 -> 1011
    t = '0;
    mark(t, 0, 1); mark(t, 0, 5);
    mark(t, 1, 2); mark(t, 1, 4);
    mark(t, 2, 3); mark(t, 2, 4);
    e = model(t, "");
    chk(e.vec === 15'b1011, "R2", "model sanity 1011", 32'(e.vec), 32'hB);
    run(t, "R2 three-stage");

    // R8: results hold while idle
    repeat (10) @(negedge clk);
    chk(cvec_o === 15'b1011, "R8", "vector held", 32'(cvec_o), 32'hB);
    chk(max_lat_o === 4'd4, "R8", "max held", 32'(max_lat_o), 4);

    // R9: empty table and one mark per row
    run('0, "R9 empty");
    t = '0;
    for (int s = 0; s < NS; s++) mark(t, s, s + 1);
    run(t, "R9 single-use");
    chk(cvec_o === '0 && max_lat_o === '0, "R9", "single-use zero", 32'(cvec_o), 0);

    // R10: full row and end-to-end marks
    t = '0;
    for (int c = 1; c <= NC; c++) mark(t, 5, c);
    run(t, "R10 full-row");
    chk(max_lat_o === LW'(NC - 1), "R10", "full-row max", 32'(max_lat_o), NC - 1);
    t = '0;
    mark(t, NS - 1, 1); mark(t, NS - 1, NC);
    run(t, "R10 end-to-end");
    chk(cvec_o === (VW'(1) << (VW - 1)), "R10", "end-to-end vector", 32'(cvec_o), 32'(VW'(1) << (VW - 1)));

    // R6 + R7: new table and start during a scan are ignored
    t = '0;
    mark(t, 2, 2); mark(t, 2, 5);
    t2 = '1;
    e = model(t, "R6 R7 mid-scan");
    d0 = dones;
    @(negedge clk);
    table_i = t;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    e.acc_cyc = cyc;
    sb.push_back(e);
    repeat (4) @(negedge clk);
    table_i = t2;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (NC + 20) @(negedge clk);
    chk(dones == d0 + 1, "R7", "single done", 32'(dones - d0), 1);
    chk(sb.size() == 0, "R6", "result delivered", 32'(sb.size()), 0);

    // R2/R3/R4 sparse random tables
    for (int k = 0; k < 12; k++) begin
      t = '0;
      for (int w = 0; w < TW / 32; w++)
        t[w*32 +: 32] = next_rand() & next_rand() & next_rand();
      run(t, "R2 random");
    end

    summary();
  end
endmodule